// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block is the timekeeping core of a real-time clock. A single-cycle `tick_i` pulse arrives every 10 ms. The core counts these pulses into eight packed-BCD byte registers: hundredths, seconds, minutes, hours, day of week, date, month and two-digit year. Carries ripple through the whole chain in one clock edge. The date wraps according to the month length, and February gains a 29th day in leap years.

Software sets the clock with a parallel load that replaces all eight bytes at once and restarts the tick prescaler. It reads the time through a 64-bit port. Every field changes on the same edge, so any sampled value is a consistent snapshot.

The hours byte works in one of two formats, 12-hour with a PM flag or 24-hour. The day byte also carries two control flags: one halts timekeeping, and the other masks an external abort request.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, `rd_data_o` reads hundredths 00, seconds 00, minutes 00, hours 0x00 (24-hour), day byte 0x31 (halt and abort-mask flags set, day 1), date 0x01, month 0x01, year 0x00.
- R2: In snapshot byte k = bits [8k+7:8k], byte 0 is hundredths, counting 00–99 in BCD. Byte 1 is seconds and byte 2 is minutes, each counting 00–59. Each field wraps to 00 and carries into the next field only on the step in which it wraps.
- R3: Day-byte bit 5 halts the clock when it is 1; while it is set, ticks change no register. When the bit is 0, each prescaler step advances the time.
- R4: Asserting `load_i` writes `load_data_i` into all eight bytes on that edge, and this takes priority over a tick. A load also clears the prescaler, so the next increment needs a full TICKS_PER_CS ticks.
- R5: Hours byte (byte 3) with bit 7 = 0 is 24-hour mode. Hours count 00–23 in BCD using bits 5:0, and 23 wraps to 00 with a carry into the day and date.
- R6: Hours byte with bit 7 = 1 is 12-hour mode. Bits 4:0 count 01–12, and bit 5 is PM. The step from 11 to 12 toggles PM, and 12 goes to 01 without a carry. Only the step from 11 PM to 12 AM carries into the day and date. Bit 7 is never changed by counting.
- R7: The day of week (bits 2:0 of byte 4) wraps from 7 to 1 on each date carry. Day-byte bits 7:3 are kept.
- R8: The date (byte 5) wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except 02. It then carries into the month (byte 6, 01–12).
- R9: February ends at 29 when the year value is divisible by 4, and at 28 otherwise. Month 12 wraps to 01 and carries into the year (byte 7), and year 99 wraps to 00.
- R10: `abort_o` is 1 exactly when `ext_abort_ni` is low and day-byte bit 4 is 0. When that bit is 1, the input is ignored.
- R11: One step from 23:59:59.99 on the last day of December, year 99, updates all eight bytes on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse every 10 ms |
| load_i | input | 1 | Parallel load strobe |
| load_data_i | input | 64 | Snapshot to load, byte k = register k |
| ext_abort_ni | input | 1 | External active-low abort request |
| rd_data_o | output | 64 | Current time snapshot, byte k = register k |
| abort_o | output | 1 | Abort request after masking |

## Verification
The hardest states to reach are the deep carry boundaries: a year-end rollover, the end of a leap-year February, and the 11 PM to 12 AM step in 12-hour mode. Counting there from reset would take years of ticks. Instead, the bench loads a snapshot one hundredth before each boundary and applies a single tick, then compares the whole 64-bit snapshot. Prescaler restart is tested on a second instance with a divide ratio of 3: a reload partway through the count must delay the next increment.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_W  = 8;
  localparam int NUM_REGS = 8;
  localparam int SNAP_W = REG_W * NUM_REGS;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd2bin(input logic [7:0] v);
    return {3'b0, v[7:4]} * 7'd10 + {3'b0, v[3:0]};
  endfunction

  // last valid date of a month, in BCD
  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    logic [6:0] yb;
    yb = bcd2bin(yr);
    case (mon)
      8'h02: return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic en_i,
  output logic step_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign step_o = en_i & tick_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (en_i && tick_i)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/rtc_mod_field.sv
module rtc_mod_field
  import rtc_pkg::*;
#(
  parameter int MAXV = 59
) (
  input  logic [7:0] val_i,
  input  logic       inc_i,
  output logic [7:0] val_o,
  output logic       carry_o
);
  localparam logic [7:0] MAX_BCD = 8'((MAXV / 10) * 16 + MAXV % 10);

  assign carry_o = inc_i & (val_i == MAX_BCD);

  always_comb begin
    val_o = val_i;
    if (inc_i) val_o = (val_i == MAX_BCD) ? 8'h00 : bcd_inc(val_i);
  end
endmodule

// File: rtl/rtc_hour_field.sv
module rtc_hour_field (
  input  logic [7:0] hr_i,
  input  logic       inc_i,
  output logic [7:0] hr_o,
  output logic       carry_o
);
  logic mode12;
  assign mode12 = hr_i[7];

  always_comb begin
    hr_o    = hr_i;
    carry_o = 1'b0;
    if (inc_i) begin
      if (mode12) begin
        if (hr_i[4:0] == 5'h11) begin
          hr_o[4:0] = 5'h12;
          hr_o[5]   = ~hr_i[5];
          carry_o   = hr_i[5];        // 11 PM -> 12 AM starts a new day
        end else if (hr_i[4:0] == 5'h12) begin
          hr_o[4:0] = 5'h01;
        end else if (hr_i[3:0] == 4'd9) begin
          hr_o[4:0] = 5'h10;
        end else begin
          hr_o[3:0] = hr_i[3:0] + 4'd1;
        end
      end else begin
        if (hr_i[5:0] == 6'h23) begin
          hr_o[5:0] = 6'h00;
          carry_o   = 1'b1;
        end else if (hr_i[3:0] == 4'd9) begin
          hr_o[5:0] = {hr_i[5:4] + 2'd1, 4'd0};
        end else begin
          hr_o[3:0] = hr_i[3:0] + 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic [7:0] day_i,
  input  logic [7:0] date_i,
  input  logic [7:0] mon_i,
  input  logic [7:0] yr_i,
  input  logic       inc_i,
  output logic [7:0] day_o,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] yr_o
);
  logic [7:0] last_date;
  logic       date_wrap, mon_wrap;

  assign last_date = month_last(mon_i, yr_i);
  assign date_wrap = inc_i & (date_i == last_date);
  assign mon_wrap  = date_wrap & (mon_i == 8'h12);

  always_comb begin
    day_o  = day_i;
    date_o = date_i;
    mon_o  = mon_i;
    yr_o   = yr_i;
    if (inc_i) begin
      day_o[2:0] = (day_i[2:0] == 3'd7) ? 3'd1 : day_i[2:0] + 3'd1;
      date_o     = date_wrap ? 8'h01 : bcd_inc(date_i);
    end
    if (date_wrap) mon_o = mon_wrap ? 8'h01 : bcd_inc(mon_i);
    if (mon_wrap)  yr_o  = (yr_i == 8'h99) ? 8'h00 : bcd_inc(yr_i);
  end
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_CS = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [SNAP_W-1:0] load_data_i,
  input  logic              ext_abort_ni,
  output logic [SNAP_W-1:0] rd_data_o,
  output logic              abort_o
);
  localparam int NUM_LOW = 3;           // hundredths, seconds, minutes
  localparam int HR  = 3;
  localparam int DAY = 4;
  localparam int DT  = 5;
  localparam int MON = 6;
  localparam int YR  = 7;
  localparam int HALT_BIT = DAY * REG_W + 5;
  localparam int MASK_BIT = DAY * REG_W + 4;
  localparam logic [SNAP_W-1:0] RST_VAL = 64'h00_01_01_31_00_00_00_00;

  logic [SNAP_W-1:0] tm_q, tm_d;
  logic [NUM_LOW:0]  cy;
  logic              step, day_cy;

  rtc_prescaler #(.DIV(TICKS_PER_CS)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load_i),
    .tick_i (tick_i),
    .en_i   (~tm_q[HALT_BIT]),
    .step_o (step)
  );

  assign cy[0] = step;

  for (genvar g = 0; g < NUM_LOW; g++) begin : g_low
    rtc_mod_field #(.MAXV((g == 0) ? 99 : 59)) u_fld (
      .val_i   (tm_q[g*REG_W +: REG_W]),
      .inc_i   (cy[g]),
      .val_o   (tm_d[g*REG_W +: REG_W]),
      .carry_o (cy[g+1])
    );
  end

  rtc_hour_field u_hr (
    .hr_i    (tm_q[HR*REG_W +: REG_W]),
    .inc_i   (cy[NUM_LOW]),
    .hr_o    (tm_d[HR*REG_W +: REG_W]),
    .carry_o (day_cy)
  );

  rtc_calendar u_cal (
    .day_i  (tm_q[DAY*REG_W +: REG_W]),
    .date_i (tm_q[DT*REG_W +: REG_W]),
    .mon_i  (tm_q[MON*REG_W +: REG_W]),
    .yr_i   (tm_q[YR*REG_W +: REG_W]),
    .inc_i  (day_cy),
    .day_o  (tm_d[DAY*REG_W +: REG_W]),
    .date_o (tm_d[DT*REG_W +: REG_W]),
    .mon_o  (tm_d[MON*REG_W +: REG_W]),
    .yr_o   (tm_d[YR*REG_W +: REG_W])
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tm_q <= RST_VAL;
    else if (load_i) tm_q <= load_data_i;
    else if (step)   tm_q <= tm_d;
  end

  assign rd_data_o = tm_q;
  assign abort_o   = ~ext_abort_ni & ~tm_q[MASK_BIT];
endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic        load_i,
  input logic [63:0] load_data_i,
  input logic [63:0] rd_data_o,
  input logic        abort_o
);
  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !tick_i |=> $stable(rd_data_o));

  assert_sec_needs_carry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && rd_data_o[7:0] != 8'h99 |=> $stable(rd_data_o[15:8]));

  assert_halt_freeze_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && rd_data_o[37] |=> $stable(rd_data_o));

  assert_load_image_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> rd_data_o == $past(load_data_i));

  assert_mode_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(rd_data_o[31]));

  assert_mask_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[36] |-> !abort_o);
endmodule

bind rtc_bcd_core rtc_bcd_core_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .load_i      (load_i),
  .load_data_i (load_data_i),
  .rd_data_o   (rd_data_o),
  .abort_o     (abort_o)
);

// File: tb/rtc_bcd_core_test.sv
module rtc_bcd_core_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b0, load = 1'b0, ext_n = 1'b1;
  logic [63:0] ld = '0;
  logic [63:0] rd;
  logic        abort;
  logic        tick_d = 1'b0, load_d = 1'b0;
  logic [63:0] ld_d = '0;
  logic [63:0] rd_d;
  logic        abort_d;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rtc_bcd_core uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .load_i(load), .load_data_i(ld),
    .ext_abort_ni(ext_n), .rd_data_o(rd), .abort_o(abort));

  rtc_bcd_core #(.TICKS_PER_CS(3)) uut_div (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_d), .load_i(load_d), .load_data_i(ld_d),
    .ext_abort_ni(1'b1), .rd_data_o(rd_d), .abort_o(abort_d));

  function automatic logic [63:0] mk(input logic [7:0] cs, s, m, h, dy, dt, mo, yr);
    return {yr, mo, dt, dy, h, m, s, cs};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [63:0] d);
    @(negedge clk); load = 1'b1; ld = d;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic step_from(input logic [63:0] d, input logic [63:0] exp, input string req);
    do_load(d);
    do_tick(1);
    chk(req, rd, exp);
  endtask

  task automatic t_reset;
    chk("R1 reset image", rd, mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h31, 8'h01, 8'h01, 8'h00));
    ext_n = 1'b0; #1;
    chk("R10 masked abort", {63'b0, abort}, 64'd0);
    ext_n = 1'b1;
  endtask

  task automatic t_halt;
    do_tick(5);
    chk("R3 halted after reset", rd, mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h31, 8'h01, 8'h01, 8'h00));
    do_load(mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00));
    do_tick(3);
    chk("R3 running", rd, mk(8'h03, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00));
    do_load(mk(8'h42, 8'h00, 8'h00, 8'h00, 8'h21, 8'h01, 8'h01, 8'h00));
    do_tick(4);
    chk("R3 halt bit set by load", rd, mk(8'h42, 8'h00, 8'h00, 8'h00, 8'h21, 8'h01, 8'h01, 8'h00));
  endtask

  task automatic t_low_carry;
    do_load(mk(8'h98, 8'h59, 8'h12, 8'h05, 8'h02, 8'h10, 8'h03, 8'h20));
    do_tick(1);
    chk("R2 hundredths 98->99", rd, mk(8'h99, 8'h59, 8'h12, 8'h05, 8'h02, 8'h10, 8'h03, 8'h20));
    do_tick(1);
    chk("R2 sec/min carry", rd, mk(8'h00, 8'h00, 8'h13, 8'h05, 8'h02, 8'h10, 8'h03, 8'h20));
    step_from(mk(8'h99, 8'h09, 8'h59, 8'h09, 8'h02, 8'h10, 8'h03, 8'h20),
              mk(8'h00, 8'h10, 8'h59, 8'h09, 8'h02, 8'h10, 8'h03, 8'h20), "R2 seconds digit carry");
    step_from(mk(8'h99, 8'h59, 8'h59, 8'h09, 8'h02, 8'h10, 8'h03, 8'h20),
              mk(8'h00, 8'h00, 8'h00, 8'h10, 8'h02, 8'h10, 8'h03, 8'h20), "R5 hour 09->10");
  endtask

  task automatic t_year_end;
    step_from(mk(8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99),
              mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00), "R11 R5 R7 R9 year end");
    step_from(mk(8'h99, 8'h59, 8'h59, 8'h23, 8'hC7, 8'h31, 8'h12, 8'h19),
              mk(8'h00, 8'h00, 8'h00, 8'h00, 8'hC1, 8'h01, 8'h01, 8'h20), "R7 R9 flags kept, year 19->20");
  endtask

  task automatic t_12h;
    step_from(mk(8'h99, 8'h59, 8'h59, 8'h91, 8'h03, 8'h15, 8'h06, 8'h21),
              mk(8'h00, 8'h00, 8'h00, 8'hB2, 8'h03, 8'h15, 8'h06, 8'h21), "R6 11AM->12PM");
    step_from(mk(8'h99, 8'h59, 8'h59, 8'hB2, 8'h03, 8'h15, 8'h06, 8'h21),
              mk(8'h00, 8'h00, 8'h00, 8'hA1, 8'h03, 8'h15, 8'h06, 8'h21), "R6 12PM->01PM");
    step_from(mk(8'h99, 8'h59, 8'h59, 8'hB1, 8'h03, 8'h15, 8'h06, 8'h21),
              mk(8'h00, 8'h00, 8'h00, 8'h92, 8'h04, 8'h16, 8'h06, 8'h21), "R6 11PM->12AM next day");
    step_from(mk(8'h99, 8'h59, 8'h59, 8'h89, 8'h03, 8'h15, 8'h06, 8'h21),
              mk(8'h00, 8'h00, 8'h00, 8'h90, 8'h03, 8'h15, 8'h06, 8'h21), "R6 09AM->10AM");
  endtask

  task automatic t_month;
    step_from(mk(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h21),
              mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h05, 8'h21), "R8 30-day month end");
    step_from(mk(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h05, 8'h21),
              mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h31, 8'h05, 8'h21), "R8 31-day month day 30");
    step_from(mk(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h11, 8'h21),
              mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h12, 8'h21), "R8 November end");
    step_from(mk(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24),
              mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h24), "R9 leap Feb 28->29");
    step_from(mk(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h24),
              mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h24), "R9 leap Feb 29 end");
    step_from(mk(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h10),
              mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h10), "R9 year 10 not leap");
    step_from(mk(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00),
              mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h00), "R9 year 00 leap");
  endtask

  task automatic t_load_prio;
    logic [63:0] d;
    d = mk(8'h55, 8'h44, 8'h33, 8'h22, 8'h05, 8'h17, 8'h08, 8'h66);
    @(negedge clk); load = 1'b1; tick = 1'b1; ld = d;
    @(negedge clk); load = 1'b0; tick = 1'b0;
    chk("R4 load beats tick", rd, d);
  endtask

  task automatic t_abort;
    do_load(mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h21, 8'h01, 8'h01, 8'h00));
    ext_n = 1'b0; #1;
    chk("R10 abort active", {63'b0, abort}, 64'd1);
    ext_n = 1'b1; #1;
    chk("R10 abort idle", {63'b0, abort}, 64'd0);
  endtask

  task automatic t_div;
    logic [63:0] d;
    d = mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    @(negedge clk); load_d = 1'b1; ld_d = d;
    @(negedge clk); load_d = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); tick_d = 1'b1;
      @(negedge clk); tick_d = 1'b0;
    end
    chk("R4 divider partial", rd_d, d);
    @(negedge clk); load_d = 1'b1;
    @(negedge clk); load_d = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); tick_d = 1'b1;
      @(negedge clk); tick_d = 1'b0;
    end
    chk("R4 prescaler restarted by load", rd_d, d);
    @(negedge clk); tick_d = 1'b1;
    @(negedge clk); tick_d = 1'b0;
    chk("R4 third tick steps", rd_d, mk(8'h01, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_halt();
    t_low_carry();
    t_year_end();
    t_12h();
    t_month();
    t_load_prio();
    t_abort();
    t_div();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule